// File: doc/BRIEF.md
# Bit-Manipulation ALU with 32-bit Word Forms

This block is a 64-bit execution unit for bit-manipulation work in a processor pipeline. It takes two operands and a 5-bit operation code and returns one result. The operations cover scaled address arithmetic, counting leading and trailing zeros, rotates and shifts, single-bit edits, shifts that fill with ones, half-word and byte packing, and byte reversal.

The word forms read only the low 32 bits of their inputs. Each one then widens its 32-bit result by the rule it defines, either sign or zero extension. Each operation masks its shift amount to the width it works on. The result is computed combinationally and captured in one output register, so a result appears at `res_o` one clock edge after its operands are presented.

Top module: `bm_alu`

## Requirements
- R1: While `rst_ni` is low, `res_o` is zero. Otherwise `res_o` takes the result for the `op_i`, `a_i` and `b_i` values sampled at each rising edge of `clk_i`. An unused code (31) gives zero.
- R2: Codes 0, 1 and 2 return `(a << k) + b` for k = 1, 2 and 3, modulo 2^64.
- R3: Codes 3, 4 and 5 return `(zext32(a) << k) + b` for k = 1, 2 and 3. Code 6 returns `zext32(a) + b`.
- R4: Codes 7, 8 and 9 set, clear or invert bit `b[5:0]` of `a`. All other bits are unchanged.
- R5: Code 10 returns bit `b[5:0]` of `a` in bit 0, with every other bit zero.
- R6: Code 11 shifts `a` left by `b[5:0]` and code 12 shifts it right by `b[5:0]`. In both, the vacated positions are filled with ones.
- R7: Code 13 counts leading zeros of `a` and code 14 counts trailing zeros. Both return 64 when `a` is zero.
- R8: Code 15 counts leading zeros and code 16 counts trailing zeros of `a[31:0]`. Both return 32 when `a[31:0]` is zero.
- R9: Code 17 rotates `a` left by `b[5:0]` and code 18 rotates it right by `b[5:0]`.
- R10: Code 19 rotates `a[31:0]` left by `b[4:0]` and code 20 rotates it right by `b[4:0]`. The 32-bit result is sign-extended.
- R11: Code 21 returns `{b[31:0], a[31:0]}` and code 22 returns `{a[63:32], b[63:32]}`. Code 23 returns `{48'b0, b[7:0], a[7:0]}`.
- R12: Codes 24, 25 and 26 perform a logical left, logical right and arithmetic right shift of `a` by `b[5:0]`.
- R13: Codes 27, 28 and 29 perform a logical left, logical right and arithmetic right shift of `a[31:0]` by `b[4:0]`. The 32-bit result is sign-extended.
- R14: Code 30 reverses the order of the eight bytes of `a`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand or shift/bit amount |
| res_o | output | 64 | Registered result |

## Verification
The bench targets the zero-input counts:
- A full-width count that saturated at 63 would return 63 instead of 64.
- A word count that ignored the upper-half conditioning would return 64 instead of 32.

It also drives shift amounts with bit 5 set into the word forms. A design that forgot the 5-bit mask would shift the result out entirely.

Rotates by zero catch a rotate built from two shifts that wraps its complement amount. Word results with bit 31 set catch a missing or zero-filling extension. Full-width checks of the ones-filling shifts and of `packh` catch stray or zero fill bits.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_SH1ADD   = 5'd0,
    OP_SH2ADD   = 5'd1,
    OP_SH3ADD   = 5'd2,
    OP_SH1ADDUW = 5'd3,
    OP_SH2ADDUW = 5'd4,
    OP_SH3ADDUW = 5'd5,
    OP_ADDUW    = 5'd6,
    OP_BSET     = 5'd7,
    OP_BCLR     = 5'd8,
    OP_BINV     = 5'd9,
    OP_BEXT     = 5'd10,
    OP_SLO      = 5'd11,
    OP_SRO      = 5'd12,
    OP_CLZ      = 5'd13,
    OP_CTZ      = 5'd14,
    OP_CLZW     = 5'd15,
    OP_CTZW     = 5'd16,
    OP_ROL      = 5'd17,
    OP_ROR      = 5'd18,
    OP_ROLW     = 5'd19,
    OP_RORW     = 5'd20,
    OP_PACK     = 5'd21,
    OP_PACKU    = 5'd22,
    OP_PACKH    = 5'd23,
    OP_SLL      = 5'd24,
    OP_SRL      = 5'd25,
    OP_SRA      = 5'd26,
    OP_SLLW     = 5'd27,
    OP_SRLW     = 5'd28,
    OP_SRAW     = 5'd29,
    OP_REV8     = 5'd30,
    OP_NONE     = 5'd31
  } bm_op_e;

  typedef enum logic [2:0] {
    SK_SLL, SK_SRL, SK_SRA, SK_ROL, SK_ROR, SK_SLO, SK_SRO
  } shift_kind_e;
endpackage

// File: rtl/bm_zero_count.sv
module bm_zero_count #(
  parameter int unsigned W    = 64,
  parameter int unsigned CNT_W = $clog2(W) + 1
) (
  input  logic [W-1:0]     v_i,
  input  logic             from_top_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [W-1:0] scan;

  // Leading count = trailing count of the bit-reversed vector.
  always_comb begin
    for (int i = 0; i < W; i++) scan[i] = from_top_i ? v_i[W-1-i] : v_i[i];
    cnt_o = CNT_W'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (scan[i]) cnt_o = CNT_W'(i);
    end
  end
endmodule

// File: rtl/bm_shifter.sv
module bm_shifter
  import bm_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0]          a_i,
  input  logic [$clog2(XLEN)-1:0]  amt_i,
  input  shift_kind_e              kind_i,
  input  logic                     word_i,
  output logic [XLEN-1:0]          res_o
);
  localparam int unsigned AW  = $clog2(XLEN);
  localparam int unsigned WW  = XLEN / 2;
  localparam int unsigned WAW = AW - 1;

  logic [WW-1:0]  wa, wres;
  logic [WAW-1:0] wamt;
  logic [XLEN-1:0] full;
  logic [AW:0]    fcomp;
  logic [WAW:0]   wcomp;

  assign wa    = a_i[WW-1:0];
  assign wamt  = amt_i[WAW-1:0];
  // Complement amounts are one bit wider so a zero amount shifts everything out.
  assign fcomp = (AW+1)'(XLEN) - {1'b0, amt_i};
  assign wcomp = (WAW+1)'(WW) - {1'b0, wamt};

  always_comb begin
    full = '0;
    wres = '0;
    case (kind_i)
      SK_SLL: begin full = a_i << amt_i; wres = wa << wamt; end
      SK_SRL: begin full = a_i >> amt_i; wres = wa >> wamt; end
      SK_SRA: begin
        full = $signed(a_i) >>> amt_i;
        wres = $signed(wa) >>> wamt;
      end
      SK_ROL: begin
        full = (a_i << amt_i) | (a_i >> fcomp);
        wres = (wa << wamt) | (wa >> wcomp);
      end
      SK_ROR: begin
        full = (a_i >> amt_i) | (a_i << fcomp);
        wres = (wa >> wamt) | (wa << wcomp);
      end
      SK_SLO: begin full = ~((~a_i) << amt_i); wres = ~((~wa) << wamt); end
      SK_SRO: begin full = ~((~a_i) >> amt_i); wres = ~((~wa) >> wamt); end
      default: begin full = '0; wres = '0; end
    endcase
    res_o = word_i ? {{WW{wres[WW-1]}}, wres} : full;
  end
endmodule

// File: rtl/bm_alu.sv
module bm_alu
  import bm_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o
);
  localparam int unsigned HALF   = XLEN / 2;
  localparam int unsigned AW     = $clog2(XLEN);
  localparam int unsigned CNT_W  = AW + 1;
  localparam int unsigned NBYTES = XLEN / 8;

  bm_op_e          op;
  logic [AW-1:0]   amt;
  logic [XLEN-1:0] a_zx, bit_mask, rev, sh_res, cz_src, res_d, res_q;
  logic            cz_top;
  logic [CNT_W-1:0] cz_cnt, cz_adj;
  shift_kind_e     sk;
  logic            sk_word;

  assign op       = bm_op_e'(op_i);
  assign amt      = b_i[AW-1:0];
  assign a_zx     = {{HALF{1'b0}}, a_i[HALF-1:0]};
  assign bit_mask = {{(XLEN-1){1'b0}}, 1'b1} << amt;

  for (genvar g = 0; g < NBYTES; g++) begin : g_rev
    assign rev[8*g +: 8] = a_i[8*(NBYTES-1-g) +: 8];
  end

  // Input conditioning for the shared zero counter.
  always_comb begin
    cz_top = 1'b0;
    cz_src = a_i;
    case (op)
      OP_CLZ:  begin cz_top = 1'b1; cz_src = a_i; end
      OP_CLZW: begin cz_top = 1'b1; cz_src = a_zx; end
      OP_CTZW: begin cz_top = 1'b0; cz_src = {{HALF{1'b1}}, a_i[HALF-1:0]}; end
      default: begin cz_top = 1'b0; cz_src = a_i; end
    endcase
  end

  bm_zero_count #(.W(XLEN), .CNT_W(CNT_W)) i_zero_count (
    .v_i       (cz_src),
    .from_top_i(cz_top),
    .cnt_o     (cz_cnt)
  );

  assign cz_adj = (op == OP_CLZW) ? cz_cnt - CNT_W'(HALF) : cz_cnt;

  always_comb begin
    sk_word = 1'b0;
    case (op)
      OP_SLL, OP_SLLW: sk = SK_SLL;
      OP_SRL, OP_SRLW: sk = SK_SRL;
      OP_SRA, OP_SRAW: sk = SK_SRA;
      OP_ROL, OP_ROLW: sk = SK_ROL;
      OP_ROR, OP_RORW: sk = SK_ROR;
      OP_SLO:          sk = SK_SLO;
      OP_SRO:          sk = SK_SRO;
      default:         sk = SK_SLL;
    endcase
    case (op)
      OP_SLLW, OP_SRLW, OP_SRAW, OP_ROLW, OP_RORW: sk_word = 1'b1;
      default: sk_word = 1'b0;
    endcase
  end

  bm_shifter #(.XLEN(XLEN)) i_shifter (
    .a_i   (a_i),
    .amt_i (amt),
    .kind_i(sk),
    .word_i(sk_word),
    .res_o (sh_res)
  );

  always_comb begin
    case (op)
      OP_SH1ADD:   res_d = (a_i << 1) + b_i;
      OP_SH2ADD:   res_d = (a_i << 2) + b_i;
      OP_SH3ADD:   res_d = (a_i << 3) + b_i;
      OP_SH1ADDUW: res_d = (a_zx << 1) + b_i;
      OP_SH2ADDUW: res_d = (a_zx << 2) + b_i;
      OP_SH3ADDUW: res_d = (a_zx << 3) + b_i;
      OP_ADDUW:    res_d = a_zx + b_i;
      OP_BSET:     res_d = a_i | bit_mask;
      OP_BCLR:     res_d = a_i & ~bit_mask;
      OP_BINV:     res_d = a_i ^ bit_mask;
      OP_BEXT:     res_d = {{(XLEN-1){1'b0}}, |(a_i & bit_mask)};
      OP_CLZ, OP_CTZ, OP_CLZW, OP_CTZW:
                   res_d = {{(XLEN-CNT_W){1'b0}}, cz_adj};
      OP_SLO, OP_SRO, OP_ROL, OP_ROR, OP_ROLW, OP_RORW,
      OP_SLL, OP_SRL, OP_SRA, OP_SLLW, OP_SRLW, OP_SRAW:
                   res_d = sh_res;
      OP_PACK:     res_d = {b_i[HALF-1:0], a_i[HALF-1:0]};
      OP_PACKU:    res_d = {a_i[XLEN-1:HALF], b_i[XLEN-1:HALF]};
      OP_PACKH:    res_d = {{(XLEN-16){1'b0}}, b_i[7:0], a_i[7:0]};
      OP_REV8:     res_d = rev;
      default:     res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_q <= '0;
    else         res_q <= res_d;
  end

  assign res_o = res_q;
endmodule

// File: rtl/bm_alu_checker.sv
module bm_alu_checker
  import bm_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [OP_W-1:0] op_i,
  input logic [XLEN-1:0] a_i,
  input logic [XLEN-1:0] b_i,
  input logic [XLEN-1:0] res_o
);
  localparam int unsigned AW   = $clog2(XLEN);
  localparam int unsigned HALF = XLEN / 2;

  logic primed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_clear_r1: assert (res_o == '0);
  end

  p_unused_code_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && $past(op_i) == OP_NONE |-> res_o == '0);

  p_bset_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && $past(op_i) == OP_BSET |-> res_o[$past(b_i[AW-1:0])]);

  p_bclr_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && $past(op_i) == OP_BCLR |-> !res_o[$past(b_i[AW-1:0])]);

  p_bext_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && $past(op_i) == OP_BEXT |-> res_o[XLEN-1:1] == '0);

  p_count_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && ($past(op_i) == OP_CLZ || $past(op_i) == OP_CTZ)
      |-> res_o <= XLEN);

  p_ctzw_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && $past(op_i) == OP_CTZW && $past(a_i[HALF-1:0]) == '0
      |-> res_o == HALF);

  p_rotw_sext_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && ($past(op_i) == OP_ROLW || $past(op_i) == OP_RORW)
      |-> (res_o[XLEN-1:HALF-1] == '0 || res_o[XLEN-1:HALF-1] == '1));

  p_packh_upper_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && $past(op_i) == OP_PACKH |-> res_o[XLEN-1:16] == '0);

  p_shw_sext_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && ($past(op_i) == OP_SLLW || $past(op_i) == OP_SRLW ||
                 $past(op_i) == OP_SRAW)
      |-> (res_o[XLEN-1:HALF-1] == '0 || res_o[XLEN-1:HALF-1] == '1));
endmodule

bind bm_alu bm_alu_checker #(.XLEN(XLEN)) i_bm_alu_checker (.*);

// File: tb/test_bm_alu.sv
module test_bm_alu;
  import bm_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op;
  logic [63:0] a, b;
  logic [63:0] res;
  int          n_run = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bm_alu i_bm_alu (.clk_i(clk), .rst_ni(rst_n), .op_i(op), .a_i(a), .b_i(b), .res_o(res));

  function automatic string req_of(int code);
    case (code)
      0, 1, 2:            return "R2";
      3, 4, 5, 6:         return "R3";
      7, 8, 9:            return "R4";
      10:                 return "R5";
      11, 12:             return "R6";
      13, 14:             return "R7";
      15, 16:             return "R8";
      17, 18:             return "R9";
      19, 20:             return "R10";
      21, 22, 23:         return "R11";
      24, 25, 26:         return "R12";
      27, 28, 29:         return "R13";
      30:                 return "R14";
      default:            return "R1";
    endcase
  endfunction

  function automatic logic [63:0] sext32(logic [31:0] v);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = (i < 32) ? v[i] : v[31];
    return r;
  endfunction

  function automatic logic [63:0] ref_model(int code, logic [63:0] x, logic [63:0] y);
    logic [63:0] r = '0;
    logic [31:0] w = '0;
    int n6 = int'(y[5:0]);
    int n5 = int'(y[4:0]);
    int c;
    logic [63:0] xz = {32'h0, x[31:0]};
    case (code)
      0: r = x * 2 + y;
      1: r = x * 4 + y;
      2: r = x * 8 + y;
      3: r = xz * 2 + y;
      4: r = xz * 4 + y;
      5: r = xz * 8 + y;
      6: r = xz + y;
      7: begin r = x; r[n6] = 1'b1; end
      8: begin r = x; r[n6] = 1'b0; end
      9: begin r = x; r[n6] = ~x[n6]; end
      10: r[0] = x[n6];
      11: for (int i = 0; i < 64; i++) r[i] = (i < n6) ? 1'b1 : x[i-n6];
      12: for (int i = 0; i < 64; i++) r[i] = (i + n6 > 63) ? 1'b1 : x[i+n6];
      13: begin c = 0; for (int i = 63; i >= 0 && !x[i]; i--) c++; r = 64'(c); end
      14: begin c = 0; for (int i = 0; i < 64 && !x[i]; i++) c++; r = 64'(c); end
      15: begin c = 0; for (int i = 31; i >= 0 && !x[i]; i--) c++; r = 64'(c); end
      16: begin c = 0; for (int i = 0; i < 32 && !x[i]; i++) c++; r = 64'(c); end
      17: for (int i = 0; i < 64; i++) r[(i + n6) % 64] = x[i];
      18: for (int i = 0; i < 64; i++) r[i] = x[(i + n6) % 64];
      19: begin for (int i = 0; i < 32; i++) w[(i + n5) % 32] = x[i]; r = sext32(w); end
      20: begin for (int i = 0; i < 32; i++) w[i] = x[(i + n5) % 32]; r = sext32(w); end
      21: r = {y[31:0], x[31:0]};
      22: r = {x[63:32], y[63:32]};
      23: r = {48'h0, y[7:0], x[7:0]};
      24: for (int i = 0; i < 64; i++) r[i] = (i < n6) ? 1'b0 : x[i-n6];
      25: for (int i = 0; i < 64; i++) r[i] = (i + n6 > 63) ? 1'b0 : x[i+n6];
      26: for (int i = 0; i < 64; i++) r[i] = (i + n6 > 63) ? x[63] : x[i+n6];
      27: begin for (int i = 0; i < 32; i++) w[i] = (i < n5) ? 1'b0 : x[i-n5]; r = sext32(w); end
      28: begin for (int i = 0; i < 32; i++) w[i] = (i + n5 > 31) ? 1'b0 : x[i+n5]; r = sext32(w); end
      29: begin for (int i = 0; i < 32; i++) w[i] = (i + n5 > 31) ? x[31] : x[i+n5]; r = sext32(w); end
      30: for (int i = 0; i < 8; i++) r[8*i +: 8] = x[8*(7-i) +: 8];
      default: r = '0;
    endcase
    return r;
  endfunction

  // Called on a falling edge: drive, wait one cycle, compare on the next falling edge.
  task automatic apply(input int code, input logic [63:0] x, input logic [63:0] y);
    logic [63:0] exp_v;
    op = 5'(code); a = x; b = y;
    exp_v = ref_model(code, x, y);
    @(negedge clk);
    n_run++;
    if (res !== exp_v) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h: got %h expected %h", req_of(code), code, x, y, res, exp_v);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_fail++;
      $display("FAIL R1 watchdog expired: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    op = 5'(OP_SH1ADD); a = 64'h1234; b = 64'h1;
    repeat (3) @(negedge clk);
    n_run++;
    if (res !== 64'h0) begin
      n_fail++;
      $display("FAIL R1 reset value: got %h expected %h", res, 64'h0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R3 scaled adds with wrap and upper-half junk
    apply(0, 64'h8000_0000_0000_0001, 64'h10);
    apply(2, 64'hF000_0000_0000_0003, 64'hFFFF_FFFF_FFFF_FFFF);
    apply(4, 64'hDEAD_BEEF_8000_0001, 64'h5);
    apply(6, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
    // R4 / R5 bit ops; amount above 63 must be masked
    apply(7, 64'h0, 64'h7F);
    apply(8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h40);
    apply(9, 64'hAAAA_AAAA_AAAA_AAAA, 64'h21);
    apply(10, 64'h8000_0000_0000_0000, 64'hFF);
    // R6 fill with ones
    apply(11, 64'h0, 64'h5);
    apply(12, 64'h0123_4567_89AB_CDEF, 64'h3F);
    // R7 / R8 zero counts
    apply(13, 64'h0, 64'h0);
    apply(14, 64'h0, 64'h0);
    apply(13, 64'h0000_0000_0000_0001, 64'h0);
    apply(15, 64'hFFFF_FFFF_0000_0000, 64'h0);
    apply(16, 64'hFFFF_FFFF_0000_0000, 64'h0);
    apply(15, 64'h0000_0000_8000_0000, 64'h0);
    // R9 / R10 rotates, including zero amount and masked word amount
    apply(17, 64'h8000_0000_0000_0001, 64'h0);
    apply(18, 64'h8000_0000_0000_0001, 64'h41);
    apply(19, 64'h1234_5678_4000_0001, 64'h21);
    apply(20, 64'h0000_0000_0000_0001, 64'h0);
    // R11 packs
    apply(21, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
    apply(22, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
    apply(23, 64'hFFFF_FFFF_FFFF_FFAB, 64'hFFFF_FFFF_FFFF_FFCD);
    // R12 / R13 shifts
    apply(26, 64'h8000_0000_0000_0000, 64'h3F);
    apply(25, 64'h8000_0000_0000_0000, 64'h7F);
    apply(27, 64'h0000_0000_0000_0001, 64'h3F);
    apply(28, 64'hFFFF_FFFF_8000_0000, 64'h20);
    apply(29, 64'h0000_0000_8000_0000, 64'h24);
    // R14 byte reverse, R1 unused code
    apply(30, 64'h0102_0304_0506_0708, 64'h0);
    apply(31, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);

    for (int k = 0; k < 4000; k++) begin
      logic [63:0] x, y;
      x = {$urandom(), $urandom()};
      y = {$urandom(), $urandom()};
      if (k % 5 == 0) x = x & {$urandom(), 32'h0};
      apply(k % 32, x, y);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule